// File: doc/BRIEF.md
# Address-space tagged translation cache

This block holds a small, fully associative set of recent page translations. Each entry maps a 20-bit virtual page number (virtual address bits [31:12], 4 KiB pages) to a physical frame number and a set of permission bits. The entry is tagged with an address-space identifier, so several address spaces can share the cache without flushing on every switch. A requester presents an identifier and a 32-bit virtual address. One cycle later it gets a hit flag, the frame and the permissions. On a miss the block raises a request toward an external table walker. The walker answers on a fill port.

A single write port takes two kinds of words. A configuration word controls three things: whether hits are served while a miss is outstanding, whether replacement is strict round-robin, and how many entries are in use. A command word invalidates entries. It can qualify by identifier and by a coarse (4 MiB) or fine (16 KiB) virtual region. Invalidation completes in the cycle the word is written.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, `miss_req` and `res_valid` are low and `lk_ready` is high. The reset configuration is 32 lines, which is clamped to the number of entries, with serve-while-pending on and round-robin off.
- R2: Result timing and content:
  - An accepted lookup (`lk_valid` and `lk_ready`) produces `res_valid` one cycle later.
  - `res_hit` is set when a valid entry among the active lines holds the same identifier and virtual address bits [31:12].
  - On a hit, `res_pfn` and `res_perm` come from that entry. On a miss both are zero.
- R3: Miss requests:
  - An accepted lookup that misses while no request is outstanding sets `miss_req` and captures the identifier and page number on `miss_asid`/`miss_vpn`.
  - These stay stable until a fill arrives, and the fill clears `miss_req`.
  - Misses that occur while a request is outstanding do not change it.
- R4: The serve-while-pending setting controls stalling:
  - When it is on, lookups are accepted while a request is outstanding.
  - When it is off, `lk_ready` is low while a request is outstanding, and a lookup offered then produces no result.
- R5: A configuration word (write with `wr_flush`=0) sets three fields:
  - bit 29: serve-while-pending;
  - bit 28: round-robin;
  - bits [5:0]: active line count N, clamped to the entry count.
  Entries at index N or above do not hit and are never chosen for a fill.
- R6: With round-robin off, a fill goes to the lowest-indexed invalid active entry. If there is none, it goes to the entry under the replacement pointer, which then advances and wraps at N.
- R7: With round-robin on, a fill always goes to the pointer entry, even if invalid active entries exist. The pointer advances and wraps at N.
- R8: A fill whose identifier and page match an existing active entry overwrites that entry and does not move the pointer. Matching copies in inactive entries are invalidated.
- R9: A command word (write with `wr_flush`=1) has match type in bits [1:0]:
  - 0 invalidates regardless of address;
  - 2 compares virtual address bits [31:22] with command bits [19:10];
  - 3 compares virtual address bits [31:14] with command bits [19:2];
  - 1 matches nothing.
- R10: Command bit 31 restricts invalidation to entries whose identifier equals command bits [30:24]. With bit 31 clear, every identifier is a candidate.
- R11: Coarse and fine region invalidation removes exactly the entries in the named region and leaves neighbours outside it valid.
- R12: A fill arriving in the same cycle as a command that matches the fill's identifier and page is discarded. A fill with a non-matching command in the same cycle is kept.
- R13: A lookup accepted in the same cycle as a command sees the entries before the command. A lookup one cycle later sees them after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_vaddr | input | 32 | Lookup virtual address (bits [11:0] ignored) |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| res_valid | output | 1 | Result of the lookup accepted last cycle |
| res_hit | output | 1 | Translation found |
| res_pfn | output | 20 | Physical frame number on hit |
| res_perm | output | 3 | Permission bits on hit |
| miss_req | output | 1 | A walk is outstanding |
| miss_asid | output | 7 | Identifier of the outstanding walk |
| miss_vpn | output | 20 | Page number of the outstanding walk |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_asid | input | 7 | Identifier of the delivered translation |
| fill_vpn | input | 20 | Page number of the delivered translation |
| fill_pfn | input | 20 | Frame number of the delivered translation |
| fill_perm | input | 3 | Permissions of the delivered translation |
| wr_en | input | 1 | Write strobe for configuration or command |
| wr_flush | input | 1 | 1: command word, 0: configuration word |
| wr_data | input | 32 | Written word |

## Verification
A corrupted valid bit, tag or replacement pointer stays hidden until a lookup touches that entry. It then shows up as a wrong `res_hit` or `res_pfn` in the cycle after the lookup. For that reason the stimulus probes neighbours on both sides of every invalidation and every eviction. A fault in the outstanding-walk state shows up at once on `miss_req`, `miss_vpn` or `lk_ready`. A behavioural model of entries, pointer and pending walk is compared with every output on every cycle, so a divergence is reported in the cycle it becomes visible.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 7,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [31:0]       lk_vaddr,
  output logic              lk_ready,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PFN_W-1:0]  res_pfn,
  output logic [PERM_W-1:0] res_perm,
  output logic              miss_req,
  output logic [ASID_W-1:0] miss_asid,
  output logic [19:0]       miss_vpn,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [19:0]       fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              wr_en,
  input  logic              wr_flush,
  input  logic [31:0]       wr_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, act, hit, same, fl_m;
  logic [ASID_W-1:0]  t_asid [ENTRIES];
  logic [19:0]        t_vpn  [ENTRIES];
  logic [PFN_W-1:0]   t_pfn  [ENTRIES];
  logic [PERM_W-1:0]  t_perm [ENTRIES];

  logic       cfg_hum, cfg_rr;
  logic [5:0] cfg_lines;
  logic [6:0] n_eff;
  logic [IDX_W-1:0] ptr, ptr_v, ptr_nx, widx, inv_i, same_i;
  logic       has_inv, has_same, use_ptr;
  logic       pend;
  logic [PFN_W-1:0]  hit_pfn;
  logic [PERM_W-1:0] hit_perm;

  wire unused_bits = ^{wr_data[23:20], lk_vaddr[11:0]};

  function automatic logic fmatch(input logic [ASID_W-1:0] a, input logic [19:0] v,
                                  input logic [31:0] d);
    logic am, vm;
    am = !d[31] || (a == d[24 +: ASID_W]);
    case (d[1:0])
      2'd0:    vm = 1'b1;
      2'd2:    vm = (v[19:10] == d[19:10]);
      2'd3:    vm = (v[19:2] == d[19:2]);
      default: vm = 1'b0;
    endcase
    return am && vm;
  endfunction

  wire [19:0] lk_vpn   = lk_vaddr[31:12];
  wire        do_flush = wr_en && wr_flush;
  wire        do_cfg   = wr_en && !wr_flush;
  wire        fill_drop = do_flush && fmatch(fill_asid, fill_vpn, wr_data);
  wire        do_fill  = fill_valid && (n_eff != 7'd0) && !fill_drop;
  wire        acc      = lk_valid && lk_ready;
  wire        any_hit  = |hit;

  assign n_eff    = ({1'b0, cfg_lines} > 7'(ENTRIES)) ? 7'(ENTRIES) : {1'b0, cfg_lines};
  assign lk_ready = !(pend && !cfg_hum);
  assign miss_req = pend;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign act[i]  = 7'(i) < n_eff;
    assign hit[i]  = vld[i] && act[i] && t_asid[i] == lk_asid && t_vpn[i] == lk_vpn;
    assign same[i] = vld[i] && t_asid[i] == fill_asid && t_vpn[i] == fill_vpn;
    assign fl_m[i] = fmatch(t_asid[i], t_vpn[i], wr_data);
  end

  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    has_inv  = 1'b0;
    inv_i    = '0;
    has_same = 1'b0;
    same_i   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i]) begin
        hit_pfn  = hit_pfn | t_pfn[i];
        hit_perm = hit_perm | t_perm[i];
      end
      if (!has_inv && act[i] && !vld[i]) begin
        has_inv = 1'b1;
        inv_i   = IDX_W'(i);
      end
      if (act[i] && same[i]) begin
        has_same = 1'b1;
        same_i   = IDX_W'(i);
      end
    end
  end

  assign ptr_v   = (7'(ptr) < n_eff) ? ptr : '0;
  assign ptr_nx  = (7'(ptr_v) + 7'd1 >= n_eff) ? '0 : ptr_v + 1'b1;
  assign use_ptr = !has_same && (cfg_rr || !has_inv);
  assign widx    = has_same ? same_i : (use_ptr ? ptr_v : inv_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      ptr       <= '0;
      cfg_hum   <= 1'b1;
      cfg_rr    <= 1'b0;
      cfg_lines <= 6'd32;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (do_flush && fl_m[i]) vld[i] <= 1'b0;
        if (do_fill && same[i] && IDX_W'(i) != widx) vld[i] <= 1'b0;
      end
      if (do_fill) vld[widx] <= 1'b1;
      if (do_fill && use_ptr) ptr <= ptr_nx;
      if (do_cfg) begin
        cfg_hum   <= wr_data[29];
        cfg_rr    <= wr_data[28];
        cfg_lines <= wr_data[5:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      t_asid[widx] <= fill_asid;
      t_vpn[widx]  <= fill_vpn;
      t_pfn[widx]  <= fill_pfn;
      t_perm[widx] <= fill_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pfn   <= '0;
      res_perm  <= '0;
      pend      <= 1'b0;
      miss_asid <= '0;
      miss_vpn  <= '0;
    end else begin
      res_valid <= acc;
      res_hit   <= acc && any_hit;
      res_pfn   <= (acc && any_hit) ? hit_pfn : '0;
      res_perm  <= (acc && any_hit) ? hit_perm : '0;
      if (pend && fill_valid) begin
        pend <= 1'b0;
      end else if (!pend && acc && !any_hit) begin
        pend      <= 1'b1;
        miss_asid <= lk_asid;
        miss_vpn  <= lk_vpn;
      end
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> res_valid);
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_pfn == '0 && res_perm == '0);
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_ready |=> !res_valid);
  p_miss_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req && !fill_valid |=> miss_req && $stable(miss_vpn) && $stable(miss_asid));
  p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req && fill_valid |=> !miss_req);
  p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_flush && wr_data[1:0] == 2'd0 && !wr_data[31] |=> vld == '0);
  p_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [6:0]  lk_asid = '0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_ready, res_valid, res_hit, miss_req;
  logic [19:0] res_pfn, miss_vpn;
  logic [2:0]  res_perm;
  logic [6:0]  miss_asid;
  logic        fill_valid = 1'b0;
  logic [6:0]  fill_asid = '0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        wr_en = 1'b0, wr_flush = 1'b0;
  logic [31:0] wr_data = '0;

  int checks = 0, errors = 0;
  bit run = 0;

  always #10 clk = ~clk;

  asid_tlb u_dut (.*);

  // behavioural reference model
  int  m_lines, m_ptr, m_masid, m_mvpn;
  bit  m_hum, m_rr, m_pend;
  bit  mv[8];
  int  ma[8], mvp[8], mpf[8], mpe[8];
  bit  e_rv, e_rh;
  int  e_pfn, e_perm;

  function automatic bit fm(int a, int v, logic [31:0] d);
    bit am, vm;
    am = !d[31] || a == int'(d[30:24]);
    case (d[1:0])
      2'd0: vm = 1;
      2'd2: vm = (v >> 10) == int'(d[19:10]);
      2'd3: vm = (v >> 2) == int'(d[19:2]);
      default: vm = 0;
    endcase
    return am && vm;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lines = 32; m_hum = 1; m_rr = 0; m_ptr = 0; m_pend = 0;
      m_masid = 0; m_mvpn = 0;
      foreach (mv[k]) mv[k] = 0;
      e_rv = 0; e_rh = 0; e_pfn = 0; e_perm = 0;
    end else begin
      int n, hi, si, ii, p, w, lv;
      bit acc, fdo, usep;
      n = (m_lines > 8) ? 8 : m_lines;
      lv = int'(lk_vaddr[31:12]);
      acc = lk_valid && !(m_pend && !m_hum);
      hi = -1; si = -1; ii = -1;
      for (int i = 0; i < n; i++) begin
        if (mv[i] && ma[i] == int'(lk_asid) && mvp[i] == lv) hi = i;
        if (mv[i] && ma[i] == int'(fill_asid) && mvp[i] == int'(fill_vpn)) si = i;
        if (ii < 0 && !mv[i]) ii = i;
      end
      fdo = fill_valid && n != 0 && !(wr_en && wr_flush && fm(fill_asid, fill_vpn, wr_data));
      p = (m_ptr < n) ? m_ptr : 0;
      usep = (si < 0) && (m_rr || ii < 0);
      w = (si >= 0) ? si : (usep ? p : ii);
      e_rv = acc;
      e_rh = acc && hi >= 0;
      e_pfn = e_rh ? mpf[hi] : 0;
      e_perm = e_rh ? mpe[hi] : 0;
      if (m_pend && fill_valid) m_pend = 0;
      else if (!m_pend && acc && hi < 0) begin
        m_pend = 1; m_masid = lk_asid; m_mvpn = lv;
      end
      for (int i = 0; i < 8; i++) begin
        bit dup;
        dup = mv[i] && ma[i] == int'(fill_asid) && mvp[i] == int'(fill_vpn);
        if (wr_en && wr_flush && mv[i] && fm(ma[i], mvp[i], wr_data)) mv[i] = 0;
        if (fdo && dup && i != w) mv[i] = 0;
      end
      if (fdo) begin
        mv[w] = 1; ma[w] = fill_asid; mvp[w] = fill_vpn; mpf[w] = fill_pfn; mpe[w] = fill_perm;
        if (usep) m_ptr = (p + 1 >= n) ? 0 : p + 1;
      end
      if (wr_en && !wr_flush) begin
        m_hum = wr_data[29]; m_rr = wr_data[28]; m_lines = int'(wr_data[5:0]);
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (run) begin
    chk(res_valid == e_rv, "R2 res_valid", res_valid, e_rv);
    if (e_rv) begin
      chk(res_hit == e_rh, "R2 res_hit", res_hit, e_rh);
      chk(int'(res_pfn) == e_pfn, "R2 res_pfn", res_pfn, e_pfn);
      chk(int'(res_perm) == e_perm, "R2 res_perm", res_perm, e_perm);
    end
    chk(miss_req == m_pend, "R3 miss_req", miss_req, m_pend);
    if (m_pend) begin
      chk(int'(miss_vpn) == m_mvpn, "R3 miss_vpn", miss_vpn, m_mvpn);
      chk(int'(miss_asid) == m_masid, "R3 miss_asid", miss_asid, m_masid);
    end
    chk(lk_ready == !(m_pend && !m_hum), "R4 lk_ready", lk_ready, !(m_pend && !m_hum));
  end

  task automatic look(int a, int v, bit exp, string tag);
    lk_valid = 1; lk_asid = 7'(a); lk_vaddr = {20'(v), 12'h5A3};
    @(negedge clk);
    lk_valid = 0;
    chk(res_hit == exp, tag, res_hit, exp);
  endtask

  task automatic fill(int a, int v, int pf, int pe);
    fill_valid = 1; fill_asid = 7'(a); fill_vpn = 20'(v); fill_pfn = 20'(pf); fill_perm = 3'(pe);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic wr(bit fl, logic [31:0] d);
    wr_en = 1; wr_flush = fl; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run = 1;
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    chk(miss_req == 0, "R1 miss_req", miss_req, 0);
    chk(lk_ready == 1, "R1 lk_ready", lk_ready, 1);
    look(1, 'h00001, 0, "R1 empty");
    chk(miss_vpn == 20'h00001 && miss_asid == 7'd1, "R3 capture", miss_vpn, 'h00001);
    fill(1, 'h00001, 'hAAAAA, 5);
    look(1, 'h00001, 1, "R2 hit");
    chk(res_pfn == 20'hAAAAA && res_perm == 3'd5, "R2 data", res_pfn, 'hAAAAA);
    look(2, 'h00001, 0, "R2 other asid");
    fill(2, 'h00001, 'hBBBBB, 3);
    look(3, 'h00100, 0, "R2 miss");
    look(1, 'h00001, 1, "R4 hit under miss");
    look(9, 'h00999, 0, "R3 second miss");
    chk(miss_vpn == 20'h00100, "R3 held", miss_vpn, 'h00100);
    fill(3, 'h00100, 'h00C00, 1);
    wr(0, 32'h0000_0020);
    look(4, 'h00200, 0, "R4 miss stall");
    chk(lk_ready == 0, "R4 stalled", lk_ready, 0);
    look(1, 'h00001, 0, "R4 not accepted");
    fill(4, 'h00200, 'h00D00, 2);
    wr(0, 32'h2000_0020);
    fill(5, 'h01000, 'h11111, 7);
    fill(5, 'h01003, 'h22222, 7);
    fill(5, 'h01004, 'h33333, 7);
    fill(6, 'h01000, 'h44444, 6);
    look(6, 'h01000, 1, "R5 clamp to 8");
    wr(1, 32'h8500_1003);
    look(5, 'h01000, 0, "R11 group");
    look(5, 'h01003, 0, "R11 group");
    look(5, 'h01004, 1, "R11 group neighbour");
    look(6, 'h01000, 1, "R10 other asid kept");
    wr(1, 32'h0000_1002);
    look(6, 'h01000, 0, "R11 section");
    look(5, 'h01004, 0, "R11 section");
    look(1, 'h00001, 1, "R11 section neighbour");
    wr(1, 32'h0000_0001);
    look(1, 'h00001, 1, "R12 type one");
    wr(1, 32'h8200_0000);
    look(2, 'h00001, 0, "R10 asid flush");
    look(1, 'h00001, 1, "R10 asid kept");
    fill(7, 'h00300, 'h55555, 1);
    fill(7, 'h00301, 'h66666, 1);
    wr(0, 32'h2000_0002);
    look(7, 'h00300, 1, "R6 first invalid");
    look(7, 'h00301, 0, "R5 inactive line");
    look(3, 'h00100, 0, "R5 inactive line");
    look(1, 'h00001, 1, "R5 active line");
    fill(8, 'h00400, 'h0AAAA, 4);
    look(1, 'h00001, 0, "R6 pointer victim");
    look(7, 'h00300, 1, "R6 pointer victim");
    look(8, 'h00400, 1, "R6 pointer victim");
    fill(8, 'h00401, 'h0BBBB, 4);
    look(7, 'h00300, 0, "R6 pointer wrap");
    fill(8, 'h00401, 'h77777, 2);
    look(8, 'h00400, 1, "R8 overwrite");
    look(8, 'h00401, 1, "R8 overwrite");
    chk(res_pfn == 20'h77777, "R8 new data", res_pfn, 'h77777);
    wr(0, 32'h3000_0003);
    wr(1, 32'h8300_0000);
    fill(9, 'h00500, 'h01010, 1);
    look(8, 'h00400, 0, "R7 skip invalid");
    fill(9, 'h00501, 'h02020, 1);
    look(8, 'h00401, 0, "R7 advance");
    fill(9, 'h00502, 'h03030, 1);
    fill(9, 'h00503, 'h04040, 1);
    look(9, 'h00500, 0, "R7 wrap");
    look(9, 'h00501, 1, "R7 wrap");
    look(9, 'h00502, 1, "R7 wrap");
    fill_valid = 1; fill_asid = 7'd10; fill_vpn = 20'h00600; fill_pfn = 20'h0F0F0; fill_perm = 3'd1;
    wr(1, 32'h8A00_0000);
    fill_valid = 0;
    look(10, 'h00600, 0, "R12 discarded");
    fill_valid = 1; fill_asid = 7'd11; fill_vpn = 20'h00700; fill_pfn = 20'h0E0E0; fill_perm = 3'd2;
    wr(1, 32'h8A00_0000);
    fill_valid = 0;
    look(11, 'h00700, 1, "R12 kept");
    wr_en = 1; wr_flush = 1; wr_data = 32'h0;
    look(11, 'h00700, 1, "R13 same cycle");
    wr_en = 0;
    look(11, 'h00700, 0, "R9 flush all");
    look(9, 'h00502, 0, "R9 flush all");
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule